// File: doc/BRIEF.md
# Segmented SRAM Bank Interface Adapter

This adapter sits between a processor-side single-port memory request and a 32 KB synchronous SRAM. The SRAM is 8K words of 4 bytes, so requests carry a 13-bit word address. A request also carries a chip select, a write enable, four byte write strobes and 32 bits of write data. The physical SRAM can be built in one of three ways, chosen by the `ORG` parameter:
- one 32-bit RAM with byte-write control;
- four 32-bit RAMs, each with byte-write control;
- four segments, each made of four 8-bit RAMs without byte-write control.

The adapter decodes each request into RAM selects, write enables, byte strobes and a RAM address. Only the RAMs an access actually touches see an active select, which keeps unused segments idle for power. In the byte-RAM organisation the write strobes become part of the select decode, giving sixteen separate byte-RAM selects. The RAMs return read data one clock after the access. The segment index of each read is registered, and in the following cycle it picks which bank's word goes back to the requester. Only synchronous RAMs are supported. Writes are gated through the selects, never through per-segment write-enable tricks.

Select and write-enable output bit `k*4+i` belongs to segment `k`, byte RAM `i` in the byte-RAM organisation, and bit `k` belongs to bank `k` in the four-bank organisation. Bank `k` read data enters on `ram_rdata[k*32 +: 32]`, and byte RAM `i` of bank `k` enters on `ram_rdata[k*32+i*8 +: 8]`.

Top module: `seg_sram_adapter`

## Requirements
- R1: While `req_cs` is 0, every bit of `ram_cs`, `ram_we` and `ram_be` is 0.
- R2: With `ORG` = one-wide, `ram_cs[0]` equals `req_cs`, `ram_we[0]` equals `req_cs & req_we`, `ram_addr` carries all 13 request address bits, and all other select bits are 0.
- R3: With either four-segment `ORG`, `ram_addr` is `{2'b00, req_addr[10:0]}`, and `req_addr[12:11]` names the only segment whose selects may be active.
- R4: With `ORG` = four-wide, a request asserts exactly `ram_cs[req_addr[12:11]]`, and a write also asserts the matching `ram_we` bit. In both byte-write organisations, `ram_be` equals `req_be` on a write and is 0 otherwise.
- R5: With `ORG` = four-byte, a read asserts all four byte-RAM selects of the addressed segment whatever `req_be` holds, and it asserts no write enable.
- R6: With `ORG` = four-byte, a write selects and write-enables exactly the byte RAMs of the addressed segment whose strobe bit is 1. A write with strobes 4'b0000 selects nothing, and `ram_be` stays 0 in this organisation.
- R7: `ram_wdata` equals `req_wdata`, so byte lane `i` reaches byte RAM `i` of every segment.
- R8: In the cycle after a read, `req_rdata` is bank `s` of `ram_rdata`, where `s` is the read's `req_addr[12:11]`. With `ORG` = one-wide it is always bank 0.
- R9: A write or an idle cycle leaves the registered read segment unchanged, so `req_rdata` keeps selecting the last read's bank.
- R10: After reset the registered read segment is 0, so `req_rdata` returns bank 0 until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_cs | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_be | input | 4 | Byte write strobes |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data returned to requester |
| ram_cs | output | 16 | Bank or byte-RAM selects |
| ram_we | output | 16 | Bank or byte-RAM write enables |
| ram_be | output | 4 | Byte strobes for byte-write capable RAMs |
| ram_addr | output | 13 | RAM word address |
| ram_wdata | output | 32 | Write data to the RAMs |
| ram_rdata | input | 128 | Read data from the four banks |

## Verification
On every clock the assertions check the following:
- an idle request drives no select;
- write enables are never active outside the selects;
- no select is active outside the addressed segment;
- the four-segment organisations never select more than one bank, and a byte-RAM read opens all four lanes;
- the registered read segment captures every read and holds across writes and idle cycles.

Only the bench scenarios can show that the exact strobe pattern reaches the right byte RAMs. They also show that the address is narrowed correctly and that returned data comes from the right bank word under random bank contents. They run all three organisations side by side, including the all-zero-strobe write and a read followed by writes to a different segment.

// File: rtl/sram_seg_pkg.sv
package sram_seg_pkg;
    typedef enum logic [1:0] {
        ORG_ONE_WIDE  = 2'd0,
        ORG_FOUR_WIDE = 2'd1,
        ORG_FOUR_BYTE = 2'd2
    } org_e;
endpackage

// File: rtl/seg_decode.sv
module seg_decode
    import sram_seg_pkg::*;
#(
    parameter org_e ORG    = ORG_FOUR_BYTE,
    parameter int   ADDR_W = 13,
    parameter int   SEG_W  = 2,
    parameter int   LANES  = 4,
    localparam int  NSEG   = 1 << SEG_W,
    localparam int  NSEL   = NSEG * LANES,
    localparam int  BANK_W = ADDR_W - SEG_W
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    output logic [NSEL-1:0]   sel,
    output logic [NSEL-1:0]   wen,
    output logic [LANES-1:0]  byte_wen,
    output logic [ADDR_W-1:0] bank_addr
);
    logic [SEG_W-1:0] seg;
    assign seg = addr[ADDR_W-1 -: SEG_W];

    generate
        if (ORG == ORG_ONE_WIDE) begin : g_one
            always_comb begin
                sel       = '0;
                wen       = '0;
                sel[0]    = cs;
                wen[0]    = cs & we;
                byte_wen  = (cs && we) ? be : '0;
                bank_addr = addr;
            end
        end else if (ORG == ORG_FOUR_WIDE) begin : g_wide
            always_comb begin
                sel = '0;
                wen = '0;
                for (int k = 0; k < NSEG; k++) begin
                    sel[k] = cs && (seg == SEG_W'(k));
                    wen[k] = cs && we && (seg == SEG_W'(k));
                end
                byte_wen  = (cs && we) ? be : '0;
                bank_addr = {{SEG_W{1'b0}}, addr[BANK_W-1:0]};
            end
        end else begin : g_byte
            always_comb begin
                for (int k = 0; k < NSEG; k++) begin
                    for (int i = 0; i < LANES; i++) begin
                        sel[k*LANES+i] = cs && (seg == SEG_W'(k)) && (!we || be[i]);
                        wen[k*LANES+i] = cs && (seg == SEG_W'(k)) && we && be[i];
                    end
                end
                byte_wen  = '0;
                bank_addr = {{SEG_W{1'b0}}, addr[BANK_W-1:0]};
            end
        end
    endgenerate
endmodule

// File: rtl/rd_return_mux.sv
module rd_return_mux
    import sram_seg_pkg::*;
#(
    parameter org_e ORG    = ORG_FOUR_BYTE,
    parameter int   SEG_W  = 2,
    parameter int   DATA_W = 32,
    localparam int  NSEG   = 1 << SEG_W
) (
    input  logic [SEG_W-1:0]       seg_q,
    input  logic [NSEG*DATA_W-1:0] bank_rdata,
    output logic [DATA_W-1:0]      rdata
);
    generate
        if (ORG == ORG_ONE_WIDE) begin : g_one
            assign rdata = bank_rdata[DATA_W-1:0];
        end else begin : g_multi
            always_comb begin
                rdata = '0;
                for (int k = 0; k < NSEG; k++) begin
                    if (seg_q == SEG_W'(k)) rdata = bank_rdata[k*DATA_W +: DATA_W];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/seg_sram_adapter.sv
module seg_sram_adapter
    import sram_seg_pkg::*;
#(
    parameter org_e ORG    = ORG_FOUR_BYTE,
    parameter int   ADDR_W = 13,
    parameter int   SEG_W  = 2,
    parameter int   LANES  = 4,
    parameter int   LANE_W = 8,
    localparam int  DATA_W = LANES * LANE_W,
    localparam int  NSEG   = 1 << SEG_W,
    localparam int  NSEL   = NSEG * LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_cs,
    input  logic                   req_we,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [LANES-1:0]       req_be,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic [DATA_W-1:0]      req_rdata,
    output logic [NSEL-1:0]        ram_cs,
    output logic [NSEL-1:0]        ram_we,
    output logic [LANES-1:0]       ram_be,
    output logic [ADDR_W-1:0]      ram_addr,
    output logic [DATA_W-1:0]      ram_wdata,
    input  logic [NSEG*DATA_W-1:0] ram_rdata
);
    typedef struct packed {
        logic [SEG_W-1:0] rd_seg;
    } state_t;

    state_t st_d, st_q;
    logic [SEG_W-1:0] rd_seg_q;

    always_comb begin
        st_d = st_q;
        if (req_cs && !req_we) st_d.rd_seg = req_addr[ADDR_W-1 -: SEG_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_seg_q  = st_q.rd_seg;
    assign ram_wdata = req_wdata;

    seg_decode #(
        .ORG(ORG), .ADDR_W(ADDR_W), .SEG_W(SEG_W), .LANES(LANES)
    ) u_dec (
        .cs(req_cs), .we(req_we), .addr(req_addr), .be(req_be),
        .sel(ram_cs), .wen(ram_we), .byte_wen(ram_be), .bank_addr(ram_addr)
    );

    rd_return_mux #(
        .ORG(ORG), .SEG_W(SEG_W), .DATA_W(DATA_W)
    ) u_mux (
        .seg_q(rd_seg_q), .bank_rdata(ram_rdata), .rdata(req_rdata)
    );
endmodule

// File: rtl/seg_sram_adapter_chk.sv
module seg_sram_adapter_chk
    import sram_seg_pkg::*;
#(
    parameter org_e ORG    = ORG_FOUR_BYTE,
    parameter int   ADDR_W = 13,
    parameter int   SEG_W  = 2,
    parameter int   LANES  = 4,
    localparam int  NSEL   = (1 << SEG_W) * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_cs,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [NSEL-1:0]   ram_cs,
    input logic [NSEL-1:0]   ram_we,
    input logic [LANES-1:0]  ram_be,
    input logic [SEG_W-1:0]  rd_seg
);
    logic [SEG_W-1:0] seg;
    logic [NSEL-1:0]  allowed;
    logic [LANES-1:0] lane_cs;

    assign seg = req_addr[ADDR_W-1 -: SEG_W];

    always_comb begin
        if (ORG == ORG_FOUR_BYTE)
            allowed = {{(NSEL-LANES){1'b0}}, {LANES{1'b1}}} << (int'(seg) * LANES);
        else if (ORG == ORG_FOUR_WIDE)
            allowed = NSEL'(1) << seg;
        else
            allowed = NSEL'(1);
        lane_cs = LANES'(ram_cs >> (int'(seg) * LANES));
    end

    // R1
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_cs |-> (ram_cs == '0 && ram_we == '0 && ram_be == '0));

    // R4, R6: a write enable never appears without its select
    a_r6_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we & ~ram_cs) == '0);

    // R2, R3: nothing outside the addressed segment is selected
    a_r3_seg_locality: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs & ~allowed) == '0);

    // R8
    a_r8_seg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cs && !req_we) |=> rd_seg == $past(req_addr[ADDR_W-1 -: SEG_W]));

    // R9
    a_r9_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_cs && !req_we) |=> rd_seg == $past(rd_seg));

    generate
        if (ORG == ORG_FOUR_WIDE) begin : g_wide
            // R4
            a_r4_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(ram_cs));
        end
        if (ORG == ORG_FOUR_BYTE) begin : g_byte
            // R5
            a_r5_read_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
                (req_cs && !req_we) |-> (lane_cs == {LANES{1'b1}} && ram_we == '0));
            // R6
            a_r6_no_byte_strobe: assert property (@(posedge clk) disable iff (!rst_n)
                ram_be == '0);
        end
    endgenerate
endmodule

bind seg_sram_adapter seg_sram_adapter_chk #(
    .ORG(ORG), .ADDR_W(ADDR_W), .SEG_W(SEG_W), .LANES(LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_cs(req_cs), .req_we(req_we),
    .req_addr(req_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_be(ram_be), .rd_seg(rd_seg_q)
);

// File: tb/tb_seg_sram_adapter.sv
module tb_seg_sram_adapter;
    import sram_seg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         req_cs = 0, req_we = 0;
    logic [12:0]  req_addr = '0;
    logic [3:0]   req_be = '0;
    logic [31:0]  req_wdata = '0;
    logic [127:0] ram_rdata = '0;

    logic [31:0] rd_o, rd_w, rd_b, wd_o, wd_w, wd_b;
    logic [15:0] cs_o, cs_w, cs_b, we_o, we_w, we_b;
    logic [3:0]  be_o, be_w, be_b;
    logic [12:0] ad_o, ad_w, ad_b;

    int total = 0, bad = 0;
    logic [1:0] exp_seg = 2'd0;

    seg_sram_adapter #(.ORG(ORG_ONE_WIDE)) dut_one (
        .clk(clk), .rst_n(rst_n), .req_cs(req_cs), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_rdata(rd_o), .ram_cs(cs_o),
        .ram_we(we_o), .ram_be(be_o), .ram_addr(ad_o), .ram_wdata(wd_o), .ram_rdata(ram_rdata));
    seg_sram_adapter #(.ORG(ORG_FOUR_WIDE)) dut_four (
        .clk(clk), .rst_n(rst_n), .req_cs(req_cs), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_rdata(rd_w), .ram_cs(cs_w),
        .ram_we(we_w), .ram_be(be_w), .ram_addr(ad_w), .ram_wdata(wd_w), .ram_rdata(ram_rdata));
    seg_sram_adapter #(.ORG(ORG_FOUR_BYTE)) dut (
        .clk(clk), .rst_n(rst_n), .req_cs(req_cs), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_rdata(rd_b), .ram_cs(cs_b),
        .ram_we(we_b), .ram_be(be_b), .ram_addr(ad_b), .ram_wdata(wd_b), .ram_rdata(ram_rdata));

    function automatic logic [15:0] f_cs(org_e o, logic c, logic w, logic [12:0] a, logic [3:0] b);
        logic [15:0] r = '0;
        int s = int'(a[12:11]);
        if (!c) return '0;
        case (o)
            ORG_ONE_WIDE:  r[0] = 1'b1;
            ORG_FOUR_WIDE: r[s] = 1'b1;
            default:       r[s*4 +: 4] = w ? b : 4'hF;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] f_we(org_e o, logic c, logic w, logic [12:0] a, logic [3:0] b);
        logic [15:0] r = '0;
        int s = int'(a[12:11]);
        if (!c || !w) return '0;
        case (o)
            ORG_ONE_WIDE:  r[0] = 1'b1;
            ORG_FOUR_WIDE: r[s] = 1'b1;
            default:       r[s*4 +: 4] = b;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] f_be(org_e o, logic c, logic w, logic [3:0] b);
        return (c && w && o != ORG_FOUR_BYTE) ? b : 4'h0;
    endfunction

    function automatic logic [12:0] f_addr(org_e o, logic [12:0] a);
        return (o == ORG_ONE_WIDE) ? a : {2'b00, a[10:0]};
    endfunction

    function automatic logic [31:0] f_rd(org_e o, logic [1:0] s, logic [127:0] bus);
        return (o == ORG_ONE_WIDE) ? bus[31:0] : bus[int'(s)*32 +: 32];
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_mode(org_e o, logic [15:0] cs, logic [15:0] we, logic [3:0] be,
                              logic [12:0] ad, logic [31:0] wd, logic [31:0] rd);
        string tg;
        logic [15:0] ec = f_cs(o, req_cs, req_we, req_addr, req_be);
        logic [15:0] ew = f_we(o, req_cs, req_we, req_addr, req_be);
        logic [3:0]  eb = f_be(o, req_cs, req_we, req_be);
        logic [31:0] er = f_rd(o, exp_seg, ram_rdata);
        if (!req_cs)                 tg = "R1";
        else if (o == ORG_ONE_WIDE)  tg = "R2";
        else if (o == ORG_FOUR_WIDE) tg = "R4";
        else if (!req_we)            tg = "R5";
        else                         tg = "R6";
        chk(cs == ec, {tg, " select"}, 128'(cs), 128'(ec));
        chk(we == ew, {tg, " write enable"}, 128'(we), 128'(ew));
        chk(be == eb, {tg, " byte strobe"}, 128'(be), 128'(eb));
        if (req_cs)
            chk(ad == f_addr(o, req_addr), (o == ORG_ONE_WIDE) ? "R2 address" : "R3 address",
                128'(ad), 128'(f_addr(o, req_addr)));
        chk(wd == req_wdata, "R7 write data", 128'(wd), 128'(req_wdata));
        chk(rd == er, "R8/R9 read return", 128'(rd), 128'(er));
    endtask

    task automatic check_all();
        check_mode(ORG_ONE_WIDE,  cs_o, we_o, be_o, ad_o, wd_o, rd_o);
        check_mode(ORG_FOUR_WIDE, cs_w, we_w, be_w, ad_w, wd_w, rd_w);
        check_mode(ORG_FOUR_BYTE, cs_b, we_b, be_b, ad_b, wd_b, rd_b);
    endtask

    task automatic step(logic c, logic w, logic [12:0] a, logic [3:0] b);
        @(negedge clk);
        req_cs = c; req_we = w; req_addr = a; req_be = b;
        req_wdata = $urandom;
        ram_rdata = {$urandom, $urandom, $urandom, $urandom};
        #1 check_all();
        @(posedge clk);
        if (req_cs && !req_we) exp_seg = req_addr[12:11];
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_0A11));
        ram_rdata = {$urandom, $urandom, $urandom, $urandom};
        repeat (3) @(posedge clk);
        #1;
        // R10: reset value of the read segment selects bank 0
        chk(rd_b == ram_rdata[31:0], "R10 reset read bank", 128'(rd_b), 128'(ram_rdata[31:0]));
        chk(rd_w == ram_rdata[31:0], "R10 reset read bank", 128'(rd_w), 128'(ram_rdata[31:0]));
        chk(cs_b == 16'h0 && cs_w == 16'h0 && cs_o == 16'h0, "R1 reset selects",
            128'({cs_o, cs_w, cs_b}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 13'h0, 4'h0);                  // R10 still bank 0 after release
        step(1'b1, 1'b0, {2'd3, 11'h2A5}, 4'h0);        // R5 read, strobes ignored
        step(1'b1, 1'b1, {2'd1, 11'h011}, 4'h0);        // R6 zero-strobe write, R9 holds seg 3
        step(1'b1, 1'b1, {2'd1, 11'h7FF}, 4'b1010);     // R6 partial strobes
        step(1'b0, 1'b1, {2'd2, 11'h123}, 4'hF);        // R1 idle with we high, R9
        step(1'b1, 1'b0, {2'd0, 11'h000}, 4'hF);        // R3 segment 0 read
        step(1'b1, 1'b1, {2'd2, 11'h400}, 4'b0001);     // R4 write bank 2
        step(1'b1, 1'b0, {2'd2, 11'h3FF}, 4'b0110);     // R8 read seg 2
        for (int n = 0; n < 2000; n++) begin
            step(($urandom % 10) < 7, $urandom % 2, 13'($urandom), 4'($urandom));
        end
        step(1'b0, 1'b0, 13'h0, 4'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule